// File: doc/BRIEF.md
# PS/2 Two-Wire Bus Monitor

This block listens passively to the open-collector clock and data lines of a PS/2 link, sampled in the system clock domain. It rebuilds every 11-bit frame and works out who sent it: the attached device or the host. Once a frame is complete, it presents the byte together with four flags on a one-cycle strobe. The flags give the traffic direction, the odd-parity verdict, the stop-bit level and, for host frames, whether the device acknowledged. The monitor never drives either line.

Both lines are synchronised and debounced before any edge is used. Each direction has its own sampling edge, chosen by a configuration input. A programmable quiet-clock timeout drops any frame that stalls, so the monitor recovers from a cable pull or a reset mid-transfer.

Top module: `ps2_bus_monitor`

## Requirements
- R1: A frame is one start bit (low), eight data bits with bit 0 first, one parity bit and one stop bit. `frm_byte_o` carries the eight data bits with the first-received bit at position 0.
- R2: `frm_par_ok_o` is 1 exactly when the eight data bits plus the parity bit hold an odd number of ones.
- R3: `frm_stop_ok_o` equals the level of the data line sampled at the stop bit, so 1 means a correct high stop.
- R4: With no frame in progress, a falling clock edge with data low starts a device frame. The bits that follow are sampled on falling edges when `cfg_dev_rise_i` is 0. The frame is reported with `frm_from_host_o` = 0 and `frm_ack_o` = 0.
- R5: With `cfg_dev_rise_i` = 1, the device start bit and all later device bits are taken on rising clock edges instead.
- R6: A falling clock edge in the same sample as a data transition marks a host request. The next rising clock edge with data low is the start bit. Host bits are then sampled on rising edges when `cfg_host_fall_i` is 0, and the frame is reported with `frm_from_host_o` = 1.
- R7: With `cfg_host_fall_i` = 1, the host data, parity and stop bits are taken on falling clock edges.
- R8: After a host stop bit, the device acknowledges by holding data low at the next falling clock edge and through the following rising edge. The report comes at that rising edge with `frm_ack_o` = 1. If data is high at that falling edge, the report comes at once with `frm_ack_o` = 0.
- R9: With no frame in progress, a falling clock edge with data high is ignored and produces no report.
- R10: In falling-edge device mode, if data falls while the clock is still low after a device stop bit, the next rising edge with data low starts a host frame.
- R11: If the filtered clock line shows no edge for `tmo_lim_i` cycles while a frame is partly received, that frame is dropped without a report and the monitor returns to idle.
- R12: After reset all outputs are 0. `frm_valid_o` is high for exactly one cycle per frame, and the other outputs change only together with the strobe.
- R13: A level change on either line that lasts fewer than FILT_LEN system cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ps2_clk_i | input | 1 | Bus clock line as seen (asynchronous) |
| ps2_dat_i | input | 1 | Bus data line as seen (asynchronous) |
| cfg_dev_rise_i | input | 1 | 1: sample device bits on rising edges |
| cfg_host_fall_i | input | 1 | 1: sample host bits on falling edges |
| tmo_lim_i | input | TMO_W | Quiet-clock limit in system cycles |
| frm_valid_o | output | 1 | One-cycle frame strobe |
| frm_byte_o | output | 8 | Received data byte |
| frm_from_host_o | output | 1 | 1: host-to-device frame |
| frm_par_ok_o | output | 1 | Odd parity satisfied |
| frm_stop_ok_o | output | 1 | Stop bit was high |
| frm_ack_o | output | 1 | Device acknowledge observed (host frames) |

## Verification
If the bit counter slips or the shift register is misaligned, the fault shows at the next strobe as a wrong byte or wrong parity flag. It can also show as a strobe that arrives one bus clock early or never arrives. If the direction state is wrong, the direction flag is wrong at that strobe, or the strobe waits for an acknowledge that never comes. A stuck state is cleared by the timeout, and the bench then sees the following frame missing or corrupted. So every internal fault is visible within one frame time of the stimulus that exposes it.

// File: rtl/ps2_mon_pkg.sv
// Shared constants and types for the PS/2 bus monitor.
package ps2_mon_pkg;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = 11;
    localparam int STOP_IDX   = FRAME_BITS - 1;
    localparam int BCNT_W     = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,     // no frame in progress
        ST_HREQ,     // host request seen, waiting for start
        ST_RX,       // collecting bits
        ST_ACK_LO,   // host frame done, waiting for ack falling edge
        ST_ACK_HI,   // ack falling edge seen with data low
        ST_DPOST     // device stop taken, watching for host takeover
    } mon_state_e;
endpackage

// File: rtl/ps2_line_cond.sv
// Conditions one asynchronous bus line: two-flop synchroniser, a filter
// that accepts a new level only after FILT_LEN stable cycles, and edge
// detection on the filtered level. Assumes the line idles high.
module ps2_line_cond #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic          filt_q;
    logic          prev_q;
    logic [CW-1:0] cnt_q;

    // Bring the line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_i};
    end

    // Accept a level only after it has held for FILT_LEN cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b1;
            cnt_q  <= '0;
        end else if (sync_q[1] == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            filt_q <= sync_q[1];
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Previous filtered level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= filt_q;
    end

    assign level_o = filt_q;
    assign rise_o  = filt_q & ~prev_q;
    assign fall_o  = ~filt_q & prev_q;
endmodule

// File: rtl/ps2_quiet_timer.sv
// Counts cycles since the last clear and flags when the count reaches a
// run-time limit. Saturates at the limit.
module ps2_quiet_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);
    logic [TMO_W-1:0] cnt_q;

    // Advance the quiet counter until it meets the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clr_i)            cnt_q <= '0;
        else if (cnt_q != limit_i) cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q == limit_i) && !clr_i;
endmodule

// File: rtl/ps2_frame_engine.sv
// Frame state machine: classifies direction, samples bits on the edge
// chosen for that direction, checks the device acknowledge after host
// frames and registers the report. Assumes filtered, edge-detected inputs.
module ps2_frame_engine
    import ps2_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c_lvl_i,
    input  logic              c_rise_i,
    input  logic              c_fall_i,
    input  logic              d_lvl_i,
    input  logic              d_rise_i,
    input  logic              d_fall_i,
    input  logic              cfg_dev_rise_i,
    input  logic              cfg_host_fall_i,
    input  logic              tmo_exp_i,
    output logic              idle_o,
    output logic              vld_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              host_o,
    output logic              par_ok_o,
    output logic              stop_ok_o,
    output logic              ack_o
);
    mon_state_e        st_q, st_d;
    logic [BCNT_W-1:0] cnt_q, cnt_d;
    logic [DATA_W:0]   sh_q, sh_d;
    logic              host_q, host_d;
    logic              stop_q, stop_d;
    logic              emit, emit_ack, emit_stop;
    logic              dev_edge, host_edge, samp_edge;

    assign dev_edge  = cfg_dev_rise_i  ? c_rise_i : c_fall_i;
    assign host_edge = cfg_host_fall_i ? c_fall_i : c_rise_i;
    assign samp_edge = host_q ? host_edge : dev_edge;
    assign idle_o    = (st_q == ST_IDLE);

    // Next-state, bit collection and report decision.
    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_q;
        sh_d      = sh_q;
        host_d    = host_q;
        stop_d    = stop_q;
        emit      = 1'b0;
        emit_ack  = 1'b0;
        emit_stop = stop_q;
        if (st_q != ST_IDLE && tmo_exp_i) begin
            st_d = ST_IDLE;
            if (st_q == ST_ACK_LO || st_q == ST_ACK_HI) emit = 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (c_fall_i && (d_rise_i || d_fall_i)) begin
                        st_d   = ST_HREQ;
                        host_d = 1'b1;
                    end else if (dev_edge && !d_lvl_i) begin
                        st_d   = ST_RX;
                        host_d = 1'b0;
                        cnt_d  = BCNT_W'(1);
                    end
                end
                ST_HREQ: begin
                    if (c_rise_i && !d_lvl_i) begin
                        st_d  = ST_RX;
                        cnt_d = BCNT_W'(1);
                    end
                end
                ST_RX: begin
                    if (samp_edge) begin
                        if (cnt_q == BCNT_W'(STOP_IDX)) begin
                            stop_d = d_lvl_i;
                            if (host_q) begin
                                st_d = ST_ACK_LO;
                            end else begin
                                emit      = 1'b1;
                                emit_stop = d_lvl_i;
                                st_d      = cfg_dev_rise_i ? ST_IDLE : ST_DPOST;
                            end
                        end else begin
                            sh_d  = {d_lvl_i, sh_q[DATA_W:1]};
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_ACK_LO: begin
                    if (c_fall_i) begin
                        if (!d_lvl_i) begin
                            st_d = ST_ACK_HI;
                        end else begin
                            emit = 1'b1;
                            st_d = ST_IDLE;
                        end
                    end
                end
                ST_ACK_HI: begin
                    if (c_rise_i) begin
                        emit     = 1'b1;
                        emit_ack = !d_lvl_i;
                        st_d     = ST_IDLE;
                    end
                end
                ST_DPOST: begin
                    if (d_fall_i && !c_lvl_i) begin
                        st_d   = ST_HREQ;
                        host_d = 1'b1;
                    end else if (c_rise_i) begin
                        st_d = ST_IDLE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            sh_q   <= '0;
            host_q <= 1'b0;
            stop_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            sh_q   <= sh_d;
            host_q <= host_d;
            stop_q <= stop_d;
        end
    end

    // Report registers, loaded only when a frame is reported.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o     <= 1'b0;
            byte_o    <= '0;
            host_o    <= 1'b0;
            par_ok_o  <= 1'b0;
            stop_ok_o <= 1'b0;
            ack_o     <= 1'b0;
        end else begin
            vld_o <= emit;
            if (emit) begin
                byte_o    <= sh_q[DATA_W-1:0];
                host_o    <= host_q;
                par_ok_o  <= ^sh_q;
                stop_ok_o <= emit_stop;
                ack_o     <= emit_ack;
            end
        end
    end
endmodule

// File: rtl/ps2_bus_monitor.sv
// Top of the passive PS/2 monitor: conditions both bus lines, runs the
// quiet-clock timer and the frame engine. Never drives the bus.
module ps2_bus_monitor
    import ps2_mon_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int TMO_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ps2_clk_i,
    input  logic             ps2_dat_i,
    input  logic             cfg_dev_rise_i,
    input  logic             cfg_host_fall_i,
    input  logic [TMO_W-1:0] tmo_lim_i,
    output logic             frm_valid_o,
    output logic [7:0]       frm_byte_o,
    output logic             frm_from_host_o,
    output logic             frm_par_ok_o,
    output logic             frm_stop_ok_o,
    output logic             frm_ack_o
);
    localparam int NLINES = 2;   // index 0: clock, 1: data

    logic [NLINES-1:0] raw, lvl, rise, fall;
    logic              idle, tmo_exp;

    assign raw = {ps2_dat_i, ps2_clk_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        ps2_line_cond #(.FILT_LEN(FILT_LEN)) cond_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw[g]),
            .level_o(lvl[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
    end

    ps2_quiet_timer #(.TMO_W(TMO_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (idle | rise[0] | fall[0]),
        .limit_i  (tmo_lim_i),
        .expired_o(tmo_exp)
    );

    ps2_frame_engine engine_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .c_lvl_i        (lvl[0]),
        .c_rise_i       (rise[0]),
        .c_fall_i       (fall[0]),
        .d_lvl_i        (lvl[1]),
        .d_rise_i       (rise[1]),
        .d_fall_i       (fall[1]),
        .cfg_dev_rise_i (cfg_dev_rise_i),
        .cfg_host_fall_i(cfg_host_fall_i),
        .tmo_exp_i      (tmo_exp),
        .idle_o         (idle),
        .vld_o          (frm_valid_o),
        .byte_o         (frm_byte_o),
        .host_o         (frm_from_host_o),
        .par_ok_o       (frm_par_ok_o),
        .stop_ok_o      (frm_stop_ok_o),
        .ack_o          (frm_ack_o)
    );
endmodule

// File: rtl/ps2_bus_monitor_chk.sv
// Property checker for ps2_bus_monitor, attached by bind. Observes ports
// only; keeps a saturating count of cycles since the raw clock line moved.
module ps2_bus_monitor_chk #(
    parameter int FILT_LEN = 4,
    parameter int TMO_W    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ps2_clk_i,
    input logic [TMO_W-1:0] tmo_lim_i,
    input logic             frm_valid_o,
    input logic [7:0]       frm_byte_o,
    input logic             frm_from_host_o,
    input logic             frm_ack_o
);
    localparam int QW = TMO_W + 2;

    logic          clk_line_q;
    logic [QW-1:0] quiet_q;

    // Track how long the raw clock line has been still.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_line_q <= 1'b1;
            quiet_q    <= '0;
        end else begin
            clk_line_q <= ps2_clk_i;
            if (ps2_clk_i != clk_line_q) quiet_q <= '0;
            else if (quiet_q != '1)      quiet_q <= quiet_q + 1'b1;
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid_o |=> !frm_valid_o); // R12
    AST_FIELDS_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frm_byte_o) |-> frm_valid_o); // R12
    AST_DEVICE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_o && !frm_from_host_o) |-> !frm_ack_o); // R8
    AST_REPORT_NEAR_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid_o |-> (quiet_q <= QW'(tmo_lim_i) + QW'(FILT_LEN + 8))); // R11
endmodule

bind ps2_bus_monitor ps2_bus_monitor_chk #(.FILT_LEN(FILT_LEN), .TMO_W(TMO_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ps2_clk_i      (ps2_clk_i),
    .tmo_lim_i      (tmo_lim_i),
    .frm_valid_o    (frm_valid_o),
    .frm_byte_o     (frm_byte_o),
    .frm_from_host_o(frm_from_host_o),
    .frm_ack_o      (frm_ack_o)
);

// File: tb/ps2_bus_monitor_tb_top.sv
`timescale 1ns/1ps
// Bench: drives bus waveforms, keeps a queue of expected reports built
// from the requirements and compares the ports on every clock.
module ps2_bus_monitor_tb_top;
    localparam int HP  = 40;      // bus half period in system cycles
    localparam int TMO = 300;
    localparam int WD  = 150000;

    typedef struct {
        logic [7:0] b;
        logic h, p, s, a;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ck = 1'b1, dat = 1'b1;
    logic        dev_rise = 1'b0, host_fall = 1'b0;
    logic        vld, host, par, stp, ack;
    logic [7:0]  byt;
    int          n_chk = 0, n_bad = 0;
    bit          running = 0, done = 0;
    exp_t        exp_q[$];
    logic        prev_vld = 1'b0;
    logic [12:0] prev_out = '0;

    always #4 clk = ~clk;

    ps2_bus_monitor #(.FILT_LEN(4), .TMO_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .ps2_clk_i(ck), .ps2_dat_i(dat),
        .cfg_dev_rise_i(dev_rise), .cfg_host_fall_i(host_fall),
        .tmo_lim_i(16'(TMO)),
        .frm_valid_o(vld), .frm_byte_o(byt), .frm_from_host_o(host),
        .frm_par_ok_o(par), .frm_stop_ok_o(stp), .frm_ack_o(ack));

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic odd_ok(logic [7:0] d, logic p);
        return (^d) ^ p;
    endfunction

    function automatic logic good_par(logic [7:0] d);
        return ~(^d);
    endfunction

    task automatic expect_frame(logic [7:0] d, logic h, logic p, logic s, logic a, string tag);
        exp_q.push_back('{b: d, h: h, p: odd_ok(d, p), s: s, a: a, tag: tag});
    endtask

    // One device-driven bit: data settles while clock is high.
    task automatic dev_bit(logic b);
        dat = b; tick(HP/2); ck = 1'b0; tick(HP); ck = 1'b1; tick(HP/2);
    endtask

    task automatic dev_frame(logic [7:0] d, logic p, logic s, string tag);
        expect_frame(d, 1'b0, p, s, 1'b0, tag);
        dev_bit(1'b0);
        for (int i = 0; i < 8; i++) dev_bit(d[i]);
        dev_bit(p);
        dev_bit(s);
        dat = 1'b1; tick(HP);
    endtask

    // Host frame; with_req=0 means the start rise was already produced.
    task automatic host_frame(logic [7:0] d, logic p, logic a, bit with_req, string tag);
        expect_frame(d, 1'b1, p, 1'b1, a, tag);
        if (with_req) begin
            ck = 1'b0; dat = 1'b0; tick(HP); ck = 1'b1; tick(HP/2);
        end
        for (int i = 0; i < 10; i++) begin
            logic bv;
            bv = (i < 8) ? d[i] : ((i == 8) ? p : 1'b1);
            if (host_fall) begin
                dat = bv; tick(HP/2); ck = 1'b0; tick(HP); ck = 1'b1; tick(HP/2);
            end else begin
                ck = 1'b0; tick(HP/2); dat = bv; tick(HP/2); ck = 1'b1; tick(HP);
            end
        end
        tick(HP/2); dat = !a; tick(HP/2);
        ck = 1'b0; tick(HP); ck = 1'b1; tick(HP/2); dat = 1'b1; tick(HP);
    endtask

    task automatic drained(string req);
        tick(20);
        chk(exp_q.size() == 0, req, "frame missing", exp_q.size(), 0);
        exp_q.delete();
    endtask

    // Compare ports every cycle against the expected-report queue.
    always @(negedge clk) begin
        if (running) begin
            logic [12:0] now;
            now = {byt, host, par, stp, ack};
            if (vld) begin
                chk(!prev_vld, "R12", "strobe longer than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected report", int'(byt), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(byt == e.b, e.tag, "R1 byte", int'(byt), int'(e.b));
                    chk(host == e.h, e.tag, "R6 direction", int'(host), int'(e.h));
                    chk(par == e.p, e.tag, "R2 parity flag", int'(par), int'(e.p));
                    chk(stp == e.s, e.tag, "R3 stop flag", int'(stp), int'(e.s));
                    chk(ack == e.a, e.tag, "R8 ack flag", int'(ack), int'(e.a));
                end
            end else if (now != prev_out) begin
                chk(1'b0, "R12", "outputs moved without strobe", int'(now), int'(prev_out));
            end
            prev_vld = vld;
            prev_out = now;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        chk({vld, byt, host, par, stp, ack} == '0, "R12", "reset outputs",
            int'({vld, byt, host, par, stp, ack}), 0);
        running = 1;
        tick(20);

        dev_frame(8'hA5, good_par(8'hA5), 1'b1, "R4");      drained("R4");
        dev_frame(8'h00, 1'b0, 1'b1, "R2");                 drained("R2");
        dev_frame(8'h3C, good_par(8'h3C), 1'b0, "R3");      drained("R3");
        // R9: isolated clock pulse with data high must be ignored
        ck = 1'b0; tick(HP); ck = 1'b1; tick(HP);
        dev_frame(8'h81, good_par(8'h81), 1'b1, "R9");      drained("R9");
        // R13: 2-cycle clock glitch with data low must be ignored
        dat = 1'b0; tick(10); ck = 1'b0; tick(2); ck = 1'b1; tick(10); dat = 1'b1; tick(10);
        dev_frame(8'h5A, good_par(8'h5A), 1'b1, "R13");     drained("R13");
        host_frame(8'hF0, good_par(8'hF0), 1'b1, 1, "R6");  drained("R6");
        host_frame(8'h12, 1'b0, 1'b0, 1, "R8");             drained("R8");
        // R10: device frame, then data falls while clock is low after the stop
        expect_frame(8'h6E, 1'b0, good_par(8'h6E), 1'b1, 1'b0, "R10");
        dev_bit(1'b0);
        for (int i = 0; i < 8; i++) dev_bit(1'((8'h6E >> i) & 1));
        dev_bit(good_par(8'h6E));
        dat = 1'b1; tick(HP/2); ck = 1'b0; tick(HP/2); dat = 1'b0; tick(HP/2);
        ck = 1'b1; tick(HP/2);
        host_frame(8'h0F, good_par(8'h0F), 1'b1, 0, "R10"); drained("R10");
        // R11: partial device frame, quiet clock past the limit
        dev_bit(1'b0); dev_bit(1'b1); dev_bit(1'b0); dev_bit(1'b1);
        dat = 1'b1; tick(TMO + 100);
        dev_frame(8'hC3, good_par(8'hC3), 1'b1, "R11");     drained("R11");
        dev_rise = 1'b1; tick(10);
        dev_frame(8'h99, good_par(8'h99), 1'b1, "R5");      drained("R5");
        host_fall = 1'b1; tick(10);
        host_frame(8'hE7, good_par(8'hE7), 1'b1, 1, "R7");  drained("R7");

        tick(20);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule